// File: doc/BRIEF.md
# Programmable Asynchronous Serial Adapter

This block is a byte-wide serial port that a processor drives through four registers. Two inputs pick the register: a register-select line and a read/write direction. A single 8-bit control word sets three things: how many clock pulses make one bit time, which of eight character formats is used, and how the transmit side behaves (request-to-send level, transmit interrupt, break). The transmitter frames each byte with a start bit, an optional parity bit and one or two stop bits. It shifts the frame out least significant bit first. The line idles at mark (logic 1).

The receiver works from its own bit-clock pulse stream. It finds and qualifies the start bit, samples each bit near its centre, and rebuilds the character. It records parity errors, framing errors and overrun in a status register. That register also shows whether the receive register is full and whether the transmit register is empty, so software can tell which side raised the shared active-low interrupt. When the divide field is written with its reset code, the whole block enters a master reset state. It stays there until a legal divide code is written.

Top module: `sio_adapter`

## Requirements
- R1: Register access is decoded from the register-select and direction inputs. With rs_i=0, a write loads the control word and a read returns the status byte {irq, parity_err, overrun, framing_err, 0, 0, tx_empty, rx_full} (bit 7 down to bit 0). With rs_i=1, a write loads the transmit data register and a read returns the receive data register.
- R2: A control word with bits[1:0]=11 is a master reset. In this state the status byte reads 0x00, txd_o stays at 1 and the receiver is held idle. Every other divide code leaves master reset and sets tx_empty. The reset value of the control word is 0x03.
- R3: A transmitted frame is a 0 start bit, then the data bits least significant first, then the parity bit when enabled, then 1-level stop bits. Word select is control bits[4:2]: 000=7 data/even/2 stop, 001=7/odd/2, 010=7/even/1, 011=7/odd/1, 100=8/none/2, 101=8/none/1, 110=8/even/1, 111=8/odd/1.
- R4: Control bits[1:0] set the number of tick pulses per bit time: 00=1, 01=16, 10=64. The same ratio applies to transmit and receive.
- R5: In the no-parity formats, no parity bit is sent and parity_err is never set.
- R6: When a received character completes with rx_full clear, the character is placed in the receive data register and rx_full is set. In 7-bit formats, bit 7 reads 0. A read of the receive data register clears rx_full.
- R7: When parity is enabled, parity_err is set if the received parity bit disagrees with the parity computed over the received data bits.
- R8: framing_err takes the value "first stop bit sampled as 0" each time a character is transferred into the receive data register. It holds that value while the character stays held.
- R9: If a character completes while rx_full is set, overrun is set. rx_full stays set, and the held character and its error flags are kept. A read of the receive data register clears both rx_full and overrun.
- R10: Control bits[6:5] set the transmit behaviour. 00: rts_no low, transmit interrupt off. 01: rts_no low, transmit interrupt on. 10: rts_no high, transmit interrupt off. 11: rts_no low, txd_o forced to 0 (break), transmit interrupt off.
- R11: irq_no is low, and status bit 7 is 1, exactly when (control bit 7 is set and rx_full is set) or (the transmit interrupt is on and tx_empty is set).
- R12: At 16 and 64 ticks per bit, a low level on the line that is gone before the middle of the start bit is dropped, and no character is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | One-cycle register access strobe |
| rs_i | input | 1 | Register select: 0 control/status, 1 data |
| rw_i | input | 1 | Direction: 1 read, 0 write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from rs_i |
| tx_tick_i | input | 1 | Transmit bit-clock pulse, one clk_i cycle wide |
| rx_tick_i | input | 1 | Receive bit-clock pulse, one clk_i cycle wide |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| rts_no | output | 1 | Request to send, active low |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
Overrun is the hardest state to reach from the ports. A second whole character must finish arriving while the first is still unread, and only then can the bench show that the first character and its flags survived. The bench drives two complete, correctly timed frames back to back on the receive line and never reads the data register between them. It reads status only, since a status read has no side effect. Parity and framing errors are reached by taking the bench's own frame for a byte and flipping the parity or stop bit before serialising it. Start-bit rejection uses a low pulse three ticks long.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 11;          // start + 8 data + parity + stop
  localparam int BODY_W  = FRAME_W - 1; // bits after the start bit
  localparam int NB_W    = 4;

  typedef enum logic [1:0] {
    DIV_1  = 2'b00,
    DIV_16 = 2'b01,
    DIV_64 = 2'b10,
    DIV_MR = 2'b11
  } div_e;

  typedef struct packed {
    logic data8;
    logic par_en;
    logic par_odd;
    logic stop2;
  } fmt_t;

  function automatic fmt_t fmt_decode(input logic [2:0] ws);
    fmt_t f;
    case (ws)
      3'b000:  f = '{data8: 1'b0, par_en: 1'b1, par_odd: 1'b0, stop2: 1'b1};
      3'b001:  f = '{data8: 1'b0, par_en: 1'b1, par_odd: 1'b1, stop2: 1'b1};
      3'b010:  f = '{data8: 1'b0, par_en: 1'b1, par_odd: 1'b0, stop2: 1'b0};
      3'b011:  f = '{data8: 1'b0, par_en: 1'b1, par_odd: 1'b1, stop2: 1'b0};
      3'b100:  f = '{data8: 1'b1, par_en: 1'b0, par_odd: 1'b0, stop2: 1'b1};
      3'b101:  f = '{data8: 1'b1, par_en: 1'b0, par_odd: 1'b0, stop2: 1'b0};
      3'b110:  f = '{data8: 1'b1, par_en: 1'b1, par_odd: 1'b0, stop2: 1'b0};
      default: f = '{data8: 1'b1, par_en: 1'b1, par_odd: 1'b1, stop2: 1'b0};
    endcase
    return f;
  endfunction

  // ticks per bit minus one
  function automatic logic [5:0] div_last(input logic [1:0] d);
    case (d)
      2'b01:   return 6'd15;
      2'b10:   return 6'd63;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic calc_par(input logic [DATA_W-1:0] d, input logic data8,
                                    input logic odd);
    logic [DATA_W-1:0] m;
    m = data8 ? d : {1'b0, d[DATA_W-2:0]};
    return (^m) ^ odd;
  endfunction
endpackage

// File: rtl/sio_tx.sv
`timescale 1ns/1ps
module sio_tx
  import sio_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [1:0]        div_i,
  input  fmt_t              fmt_i,
  input  logic              brk_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              txd_o,
  output logic              tdre_o
);
  logic [CNT_W-1:0]  pre_q, last;
  logic              bit_stb;
  logic [DATA_W-1:0] hold_q;
  logic              pend_q;
  logic [BODY_W-1:0] sr_q, body;
  logic [NB_W-1:0]   left_q, nbits;
  logic              txd_q, par;

  assign last    = CNT_W'(div_last(div_i));
  assign bit_stb = tick_i && (pre_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (clr_i)              pre_q <= '0;
    else if (tick_i)             pre_q <= (pre_q == last) ? '0 : pre_q + 1'b1;
  end

  assign par = calc_par(hold_q, fmt_i.data8, fmt_i.par_odd);

  // frame body after the start bit; unused upper bits stay at mark
  always_comb begin
    body = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < DATA_W - 1 || fmt_i.data8) body[i] = hold_q[i];
    end
    if (fmt_i.par_en) begin
      if (fmt_i.data8) body[DATA_W]   = par;
      else             body[DATA_W-1] = par;
    end
    nbits = NB_W'(DATA_W - 1) + NB_W'(fmt_i.data8) + NB_W'(fmt_i.par_en)
          + (fmt_i.stop2 ? NB_W'(2) : NB_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      sr_q   <= '1;
      left_q <= '0;
      txd_q  <= 1'b1;
    end else if (clr_i) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      sr_q   <= '1;
      left_q <= '0;
      txd_q  <= 1'b1;
    end else begin
      if (bit_stb) begin
        if (left_q != '0) begin
          txd_q  <= sr_q[0];
          sr_q   <= {1'b1, sr_q[BODY_W-1:1]};
          left_q <= left_q - 1'b1;
        end else if (pend_q) begin
          txd_q  <= 1'b0;
          sr_q   <= body;
          left_q <= nbits;
          pend_q <= 1'b0;
        end else begin
          txd_q  <= 1'b1;
        end
      end
      // a write in the load cycle queues the next byte
      if (wr_i) begin
        hold_q <= wdata_i;
        pend_q <= 1'b1;
      end
    end
  end

  assign tdre_o = !clr_i && !pend_q;
  assign txd_o  = brk_i ? 1'b0 : txd_q;

  p_load_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && $past(pend_q) && !$past(clr_i) && !$past(wr_i)) |-> !txd_q);

  p_empty_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tdre_o) |-> (clr_i || $past(wr_i)));
endmodule

// File: rtl/sio_rx.sv
`timescale 1ns/1ps
module sio_rx
  import sio_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [1:0]        div_i,
  input  logic              data8_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdr_o,
  output logic              rdrf_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              ovrn_o
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA} rx_st_e;

  rx_st_e            st_q;
  logic [1:0]        sync_q;
  logic              rx;
  logic [CNT_W-1:0]  cnt_q, last, half;
  logic [NB_W-1:0]   idx_q, nb;
  logic [BODY_W-1:0] sh_q;
  logic [DATA_W-1:0] rdr_q, dat;
  logic              rdrf_q, fe_q, pe_q, ovrn_q;
  logic              done, par_bit, full_eff;

  assign rx   = sync_q[1];
  assign last = CNT_W'(div_last(div_i));
  assign half = last >> 1;
  assign nb   = NB_W'(DATA_W - 1) + NB_W'(data8_i) + NB_W'(par_en_i) + NB_W'(1);
  assign dat  = data8_i ? sh_q[DATA_W-1:0] : {1'b0, sh_q[DATA_W-2:0]};
  assign par_bit  = data8_i ? sh_q[DATA_W] : sh_q[DATA_W-1];
  assign done     = (st_q == S_DATA) && tick_i && (cnt_q == last) && (idx_q == nb - 1'b1);
  assign full_eff = rdrf_q && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
    end else if (tick_i) begin
      case (st_q)
        S_IDLE: if (!rx) begin
          cnt_q <= '0;
          idx_q <= '0;
          st_q  <= (last == '0) ? S_DATA : S_START;
        end
        S_START: begin
          if (cnt_q == half) begin
            cnt_q <= '0;
            st_q  <= rx ? S_IDLE : S_DATA;  // qualify start at mid-bit
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt_q == last) begin
            cnt_q       <= '0;
            sh_q[idx_q] <= rx;
            if (idx_q == nb - 1'b1) st_q  <= S_IDLE;
            else                    idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_q  <= '0;
      rdrf_q <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      ovrn_q <= 1'b0;
    end else if (clr_i) begin
      rdr_q  <= '0;
      rdrf_q <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      ovrn_q <= 1'b0;
    end else begin
      if (rd_i) begin
        rdrf_q <= 1'b0;
        ovrn_q <= 1'b0;
      end
      if (done) begin
        if (full_eff) begin
          ovrn_q <= 1'b1;
        end else begin
          rdr_q  <= dat;
          rdrf_q <= 1'b1;
          fe_q   <= !rx;
          pe_q   <= par_en_i && (par_bit != calc_par(dat, data8_i, par_odd_i));
        end
      end
    end
  end

  assign rdr_o  = rdr_q;
  assign rdrf_o = rdrf_q;
  assign fe_o   = fe_q;
  assign pe_o   = pe_q;
  assign ovrn_o = ovrn_q;

  p_ovrn_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovrn_q |-> rdrf_q);

  p_full_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdrf_q) |-> ($past(rd_i) || $past(clr_i)));

  p_fe_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdrf_q && $past(rdrf_q) && !$past(rd_i) && !$past(clr_i)) |-> $stable(fe_q));
endmodule

// File: rtl/sio_adapter.sv
`timescale 1ns/1ps
module sio_adapter
  import sio_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_tick_i,
  input  logic              rx_tick_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              rts_no,
  output logic              irq_no
);
  localparam logic [DATA_W-1:0] CTRL_RST = {{(DATA_W-2){1'b0}}, DIV_MR};

  logic [DATA_W-1:0] ctrl_q, rdr, status;
  logic              wr_ctrl, wr_tx, rd_rx, mr, brk, tie, rie, irq;
  logic [1:0]        txctl;
  logic              tdre, rdrf, fe, pe, ovrn;
  fmt_t              fmt;

  assign wr_ctrl = cs_i && !rw_i && !rs_i;
  assign wr_tx   = cs_i && !rw_i &&  rs_i;
  assign rd_rx   = cs_i &&  rw_i &&  rs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RST;
    else if (wr_ctrl) ctrl_q <= wdata_i;
  end

  assign mr    = (div_e'(ctrl_q[1:0]) == DIV_MR);
  assign fmt   = fmt_decode(ctrl_q[4:2]);
  assign txctl = ctrl_q[6:5];
  assign rie   = ctrl_q[7];
  assign tie   = (txctl == 2'b01);
  assign brk   = (txctl == 2'b11) && !mr;

  sio_tx #(.CNT_W(CNT_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (mr),
    .tick_i  (tx_tick_i),
    .div_i   (ctrl_q[1:0]),
    .fmt_i   (fmt),
    .brk_i   (brk),
    .wr_i    (wr_tx),
    .wdata_i (wdata_i),
    .txd_o   (txd_o),
    .tdre_o  (tdre)
  );

  sio_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (mr),
    .tick_i    (rx_tick_i),
    .div_i     (ctrl_q[1:0]),
    .data8_i   (fmt.data8),
    .par_en_i  (fmt.par_en),
    .par_odd_i (fmt.par_odd),
    .rxd_i     (rxd_i),
    .rd_i      (rd_rx),
    .rdr_o     (rdr),
    .rdrf_o    (rdrf),
    .fe_o      (fe),
    .pe_o      (pe),
    .ovrn_o    (ovrn)
  );

  assign irq     = (rie && rdrf) || (tie && tdre);
  assign status  = {irq, pe, ovrn, fe, 2'b00, tdre, rdrf};
  assign rdata_o = rs_i ? rdr : status;
  assign irq_no  = !irq;
  assign rts_no  = (txctl == 2'b10);

  p_mr_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr && $past(mr)) |-> (status == '0 && txd_o && irq_no));

  p_irq_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (rdrf || tdre));

  p_brk_no_txirq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txctl == 2'b11 && !rdrf) |-> irq_no);
endmodule

// File: tb/tb_sio_adapter.sv
`timescale 1ns/1ps
module tb_sio_adapter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rs = 1'b0, rw = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic       lb = 1'b0, rxd_drv = 1'b1;
  logic       txd, rts_n, irq_n, rxd;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;
  assign rxd = lb ? txd : rxd_drv;

  sio_adapter dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rs_i(rs), .rw_i(rw),
    .wdata_i(wdata), .rdata_o(rdata), .tx_tick_i(tick), .rx_tick_i(tick),
    .rxd_i(rxd), .txd_o(txd), .rts_no(rts_n), .irq_no(irq_n)
  );

  // tick every 4th clock, driven away from the rising edge
  initial begin
    int tk;
    tk = 0;
    forever begin
      @(negedge clk);
      tick = (tk == 3);
      tk = (tk + 1) % 4;
    end
  end

  // {ctrl, data}; every data bit0=1 so the start bit is a clean low
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    16'h01_35, 16'h05_CB, 16'h08_7F, 16'h0D_2D,
    16'h11_A5, 16'h16_C3, 16'h18_81, 16'h1D_F1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic r, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; rs = r; rw = 1'b0; wdata = d;
    @(negedge clk); cs = 1'b0; rw = 1'b1;
  endtask

  task automatic bus_rd(input logic r, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; rs = r; rw = 1'b1;
    #1 d = rdata;
    @(negedge clk); cs = 1'b0; rs = 1'b0;
  endtask

  function automatic int cpb(input logic [7:0] c);
    case (c[1:0])
      2'b01:   return 64;
      2'b10:   return 256;
      default: return 4;
    endcase
  endfunction

  function automatic logic [7:0] rx_exp(input logic [7:0] c, input logic [7:0] d);
    return c[4] ? d : {1'b0, d[6:0]};
  endfunction

  // independent frame model: bits[0] is the start bit
  task automatic exp_frame(input logic [7:0] c, input logic [7:0] d,
                           output logic [10:0] bits, output int nb);
    int  dl, st;
    bit  pen, odd;
    logic p;
    dl  = c[4] ? 8 : 7;
    pen = !(c[4:2] == 3'b100 || c[4:2] == 3'b101);
    odd = c[2];
    st  = (c[4:2] == 3'b000 || c[4:2] == 3'b001 || c[4:2] == 3'b100) ? 2 : 1;
    bits = '1;
    bits[0] = 1'b0;
    p = odd;
    for (int i = 0; i < dl; i++) begin
      bits[1+i] = d[i];
      p = p ^ d[i];
    end
    if (pen) bits[1+dl] = p;
    nb = 1 + dl + (pen ? 1 : 0) + st;
  endtask

  task automatic cap_frame(input int per, input int nb, output logic [10:0] got);
    int w;
    got = '1;
    w = 0;
    while (txd !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
    repeat (per / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (per) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic send_rx(input logic [10:0] bits, input int nb, input int per);
    for (int i = 0; i < nb; i++) begin
      rxd_drv = bits[i];
      repeat (per) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  task automatic wait_full(output logic [7:0] s);
    s = '0;
    for (int i = 0; i < 3000; i++) begin
      bus_rd(1'b0, s);
      if (s[0]) break;
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [7:0]  s, d, c;
    logic [10:0] fr, got;
    int          nb;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    bus_rd(1'b0, s);
    chk("R2 reset status", s, 8'h00);
    chk("R2 reset txd", txd, 1'b1);
    chk("R11 reset irq", irq_n, 1'b1);
    chk("R10 reset rts", rts_n, 1'b0);

    // table: loopback of every format
    for (int v = 0; v < NV; v++) begin
      c = VEC[v][15:8];
      d = VEC[v][7:0];
      lb = 1'b1;
      bus_wr(1'b0, 8'h03);
      bus_wr(1'b0, c);
      bus_rd(1'b0, s);
      chk("R1 tx empty after leaving reset", s, 8'h02);
      exp_frame(c, d, fr, nb);
      bus_wr(1'b1, d);
      cap_frame(cpb(c), nb, got);
      chk($sformatf("R3/R4/R5 frame vec%0d", v), got, fr);
      wait_full(s);
      chk($sformatf("R6 full vec%0d", v), s[0], 1'b1);
      chk($sformatf("R5/R7/R8/R9 no errors vec%0d", v), s & 8'h70, 8'h00);
      bus_rd(1'b1, d);
      chk($sformatf("R6 data vec%0d", v), d, rx_exp(c, VEC[v][7:0]));
      bus_rd(1'b0, s);
      chk($sformatf("R6 read clears vec%0d", v), s[0], 1'b0);
    end
    lb = 1'b0;
    rxd_drv = 1'b1;

    // transmit control modes
    bus_wr(1'b0, 8'h03);
    bus_wr(1'b0, 8'h15);
    bus_rd(1'b0, s);
    chk("R1 status idle", s, 8'h02);
    chk("R11 no irq when tx irq off", irq_n, 1'b1);
    bus_wr(1'b0, 8'h35);
    bus_rd(1'b0, s);
    chk("R11 status irq bit", s, 8'h82);
    chk("R10 tx irq on", irq_n, 1'b0);
    bus_wr(1'b0, 8'h55);
    @(negedge clk);
    chk("R10 rts high", rts_n, 1'b1);
    chk("R10 irq off in mode 10", irq_n, 1'b1);
    bus_wr(1'b0, 8'h75);
    repeat (2) @(negedge clk);
    chk("R10 break level", txd, 1'b0);
    chk("R10 break no irq", irq_n, 1'b1);
    chk("R10 break rts", rts_n, 1'b0);

    // parity error: 8E1, /16
    bus_wr(1'b0, 8'h03);
    bus_wr(1'b0, 8'h19);
    exp_frame(8'h19, 8'h03, fr, nb);
    fr[9] = ~fr[9];
    send_rx(fr, nb, 64);
    wait_full(s);
    chk("R7 parity error flag", s & 8'h71, 8'h41);
    bus_rd(1'b1, d);
    chk("R6 data with parity error", d, 8'h03);

    // framing error then a clean character
    exp_frame(8'h19, 8'h5A, fr, nb);
    fr[10] = 1'b0;
    send_rx(fr, nb, 64);
    wait_full(s);
    chk("R8 framing error set", s & 8'h71, 8'h11);
    bus_rd(1'b1, d);
    chk("R8 data with framing error", d, 8'h5A);
    exp_frame(8'h19, 8'h66, fr, nb);
    send_rx(fr, nb, 64);
    wait_full(s);
    chk("R8 framing error cleared by next char", s & 8'h71, 8'h01);
    bus_rd(1'b1, d);

    // overrun with receive interrupt enabled
    bus_wr(1'b0, 8'h99);
    @(negedge clk);
    chk("R11 no irq before char", irq_n, 1'b1);
    exp_frame(8'h99, 8'h11, fr, nb);
    send_rx(fr, nb, 64);
    wait_full(s);
    chk("R11 rx irq", irq_n, 1'b0);
    exp_frame(8'h99, 8'h22, fr, nb);
    send_rx(fr, nb, 64);
    repeat (200) @(negedge clk);
    bus_rd(1'b0, s);
    chk("R9 overrun flags", s & 8'hF1, 8'hA1);
    bus_rd(1'b1, d);
    chk("R9 first char kept", d, 8'h11);
    bus_rd(1'b0, s);
    chk("R9 read clears full and overrun", s & 8'h21, 8'h00);
    chk("R11 irq released", irq_n, 1'b1);

    // short low pulse is not a start bit
    bus_wr(1'b0, 8'h19);
    rxd_drv = 1'b0;
    repeat (12) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (64 * 12) @(negedge clk);
    bus_rd(1'b0, s);
    chk("R12 glitch ignored", s[0], 1'b0);
    exp_frame(8'h19, 8'hB7, fr, nb);
    send_rx(fr, nb, 64);
    wait_full(s);
    bus_rd(1'b1, d);
    chk("R12 receiver recovers", d, 8'hB7);

    // master reset with a character held
    exp_frame(8'h19, 8'h4E, fr, nb);
    send_rx(fr, nb, 64);
    wait_full(s);
    chk("R6 full before master reset", s[0], 1'b1);
    bus_wr(1'b0, 8'h1B);
    bus_rd(1'b0, s);
    chk("R2 master reset clears status", s, 8'h00);
    chk("R2 master reset idles txd", txd, 1'b1);
    bus_wr(1'b0, 8'h19);
    bus_rd(1'b0, s);
    chk("R2 leave master reset", s, 8'h02);

    finish_up();
  end
endmodule